// File: doc/BRIEF.md
# LCD Raster Sync Timing Generator

This block produces the line and frame timing for a raster LCD panel from one shared set of counters. It supports two panel styles. In active-matrix mode the block drives a free-running shift clock, a horizontal sync, a vertical sync, a data-valid enable and line data. In passive mode the same three control outputs act as the line pulse, the first-line marker and the AC-drive pin. In this mode the shift clock toggles only while pixel data is being shifted.

One pixel period lasts two cycles of `clk`. Line data and all timing state change at the start of a pixel period, and the shift clock is derived from the same internal phase. A pixel source feeds the block through a pop strobe. On each clock edge where `pix_pop` is high, the block takes `pix_data`, and that word appears on `lcd_data` for the following pixel period.

The timing inputs, the mode and the four polarity inputs are copied into a shadow register while reset is held and at every frame start. A write made in the middle of a frame therefore takes effect with the next frame.

Top module: `lcd_raster_timer`

## Requirements
- R1: While `rst_n` is low, every sync, enable and clock output sits at its inactive level with its polarity input applied: `lcd_hsync`=`pol_hs`, `lcd_vsync`=`pol_vs`, `lcd_oe`=`pol_oe`, `lcd_sclk`=`pol_clk`. `lcd_data` is 0 and `pix_pop` is 0.
- R2: Each line runs in this order: a horizontal sync of `hsync_len` pixel periods, then a gap of `gap_pre`+2 periods, then `xmax` active periods, then `gap_post` periods before the next sync. A pixel period is 2 clocks.
- R3: The output enable is active only for the `xmax` data periods of an active line, and `lcd_data` is 0 whenever it is inactive. Words popped through `pix_pop` appear on `lcd_data` in pop order, one per pixel period, and there are exactly `xmax`·`ymax` pops per frame.
- R4: The vertical sync becomes active in the same cycle as the horizontal sync of the first line of a frame, and it stays active for exactly one line period.
- R5: A frame has `ymax` lines in active-matrix mode (`mode_tft`=1). In passive mode it has `ymax`+`frame_wait` lines, and only the first `ymax` of those lines carry enabled data.
- R6: In active-matrix mode the shift clock changes level on every clock cycle, including during blanking and sync. It is inverted automatically, so with `pol_clk`=0 it falls at the instant line data changes.
- R7: In passive mode the shift clock rests at its inactive level outside enabled data. With `pol_clk`=0, line data changes only on the rising edge of the shift clock, so the panel captures data on the falling edge.
- R8: A polarity input of 1 makes the matching sync or enable output active-low. `pol_clk`=1 inverts the shift clock.
- R9: Timing, mode and polarity inputs are sampled only at a frame start. A change made mid-frame leaves the rest of that frame unchanged and takes effect from the next vertical sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, two cycles per pixel |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_tft | input | 1 | 1 = active-matrix timing, 0 = passive |
| xmax | input | XW | Active pixels per line (at least 1) |
| ymax | input | YW | Active lines per frame (at least 1) |
| hsync_len | input | HW | Horizontal sync width in pixels (at least 1) |
| gap_post | input | HW | Pixels from end of data to next sync |
| gap_pre | input | HW | Sync-to-data gap minus two |
| frame_wait | input | YW | Extra blank lines per frame in passive mode |
| pol_vs | input | 1 | 1 = active-low vertical sync |
| pol_hs | input | 1 | 1 = active-low horizontal sync |
| pol_clk | input | 1 | 1 = inverted shift clock |
| pol_oe | input | 1 | 1 = active-low output enable |
| pix_data | input | DW | Next pixel word from the source |
| pix_pop | output | 1 | Word on pix_data is taken at this edge |
| lcd_sclk | output | 1 | Panel shift clock |
| lcd_hsync | output | 1 | Horizontal sync / line pulse |
| lcd_vsync | output | 1 | Vertical sync / first-line marker |
| lcd_oe | output | 1 | Output enable / AC-drive pin |
| lcd_data | output | DW | Line data |

## Verification
A wrong phase or pixel count shows at the ports within one line. It appears as a sync, gap or enable window whose length differs from twice the programmed count. A wrong line counter shows within one frame, as the wrong number of horizontal syncs between vertical syncs or as enabled data on a passive wait line. An error in shadow loading shows on the first line after a mid-frame write, when that line takes the new width instead of the old one. Errors in the shift-clock and data phase relation show on the very next data change. They appear as data moving on the wrong shift-clock edge, or as a passive clock that toggles during blanking.

// File: rtl/lcd_timing_pkg.sv
// Shared types for the LCD raster timer.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lcd_timing_pkg;

    // Position of the timer within one line.
    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SYNC  = 3'd1,
        PH_BACK  = 3'd2,
        PH_ACT   = 3'd3,
        PH_FRONT = 3'd4
    } hphase_t;

endpackage

// File: rtl/lcd_cfg_shadow.sv
// Holds a copy of the configuration inputs for the current frame.
// Assumes: load pulses for one clock at each frame start. While reset is
// held, the copy tracks the inputs so the first frame uses them.
module lcd_cfg_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the configuration during reset or at a frame start.
    always_ff @(posedge clk) begin
        if (!rst_n || load) q <= d;
    end

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/lcd_line_seq.sv
// Horizontal sequencer: sync, pre-data gap, active pixels, post-data gap.
// Assumes: hsync_len >= 1 and xmax >= 1. A gap_post of 0 skips the
// post-data phase. One pixel period is two clocks; state advances on the
// clock where the phase bit is low (step).
module lcd_line_seq
    import lcd_timing_pkg::*;
#(
    parameter int XW = 10,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [XW-1:0] xmax,
    input  logic [HW-1:0] hsync_len,
    input  logic [HW-1:0] gap_post,
    input  logic [HW-1:0] gap_pre,
    output logic          ph,
    output logic          step,
    output hphase_t       hph,
    output logic          line_start,
    output logic          first_start,
    output logic          into_act
);

    localparam int CW = (XW > HW + 1) ? XW : HW + 1;

    logic [CW-1:0] hcnt;
    logic [CW-1:0] len;
    logic          done;
    hphase_t       hph_nx;

    assign step = !ph;

    // Length of the current phase in pixel periods.
    always_comb begin
        case (hph)
            PH_SYNC:  len = CW'(hsync_len);
            PH_BACK:  len = CW'(gap_pre) + CW'(2);
            PH_ACT:   len = CW'(xmax);
            PH_FRONT: len = CW'(gap_post);
            default:  len = CW'(1);
        endcase
    end

    assign done = (hcnt == len - CW'(1));

    // Phase that follows the current one once it is done.
    always_comb begin
        case (hph)
            PH_IDLE:  hph_nx = PH_SYNC;
            PH_SYNC:  hph_nx = PH_BACK;
            PH_BACK:  hph_nx = PH_ACT;
            PH_ACT:   hph_nx = (gap_post == '0) ? PH_SYNC : PH_FRONT;
            default:  hph_nx = PH_SYNC;
        endcase
    end

    assign first_start = step && (hph == PH_IDLE);
    assign line_start  = step && done && (hph != PH_IDLE) && (hph_nx == PH_SYNC);
    assign into_act    = step && (((hph == PH_BACK) && done) ||
                                  ((hph == PH_ACT) && !done));

    // Pixel phase bit: one pixel period is two clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= 1'b0;
        else        ph <= !ph;
    end

    // Phase and pixel counter, advanced once per pixel period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hph  <= PH_IDLE;
            hcnt <= '0;
        end else if (step) begin
            if (done) begin
                hph  <= hph_nx;
                hcnt <= '0;
            end else begin
                hcnt <= hcnt + CW'(1);
            end
        end
    end

    assert_hcnt_in_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hph != PH_IDLE) |-> (hcnt < len));
    assert_phase_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(hph));

endmodule

// File: rtl/lcd_frame_seq.sv
// Vertical sequencer: counts lines and marks the first and active lines.
// Assumes: ymax >= 1. In passive mode frame_wait blank lines follow the
// active lines; in active-matrix mode there are none.
module lcd_frame_seq #(
    parameter int YW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_tft,
    input  logic [YW-1:0] ymax,
    input  logic [YW-1:0] frame_wait,
    input  logic          line_start,
    input  logic          first_start,
    output logic          frame_load,
    output logic          v_first,
    output logic          v_active
);

    localparam int LW = YW + 1;

    logic [LW-1:0] vline;
    logic [LW-1:0] total;
    logic          last_line;

    assign total     = LW'(ymax) + (mode_tft ? LW'(0) : LW'(frame_wait));
    assign last_line = (vline == total - LW'(1));
    assign frame_load = first_start || (line_start && last_line);
    assign v_first   = (vline == '0);
    assign v_active  = (vline < LW'(ymax));

    // Line counter, wrapped at the end of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          vline <= '0;
        else if (line_start) vline <= last_line ? '0 : vline + LW'(1);
    end

    assert_vline_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vline < total);

endmodule

// File: rtl/lcd_pin_drive.sv
// Pin stage: decodes sync and enable levels, holds line data, applies
// polarity, and forms the shift clock for each panel mode.
// Assumes: polarity and mode come from the frame shadow copy.
module lcd_pin_drive
    import lcd_timing_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ph,
    input  logic          step,
    input  hphase_t       hph,
    input  logic          v_first,
    input  logic          v_active,
    input  logic          into_act,
    input  logic          mode_tft,
    input  logic          pol_vs,
    input  logic          pol_hs,
    input  logic          pol_clk,
    input  logic          pol_oe,
    input  logic [DW-1:0] pix_data,
    output logic          pix_pop,
    output logic          lcd_sclk,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_oe,
    output logic [DW-1:0] lcd_data
);

    logic          hs_i, vs_i, oe_i, run, sclk_raw;
    logic [DW-1:0] data_q;

    assign run   = (hph != PH_IDLE);
    assign hs_i  = (hph == PH_SYNC);
    assign vs_i  = run && v_first;
    assign oe_i  = (hph == PH_ACT) && v_active;
    assign pix_pop = into_act && v_active;

    // Active-matrix clock runs inverted and free; passive only during data.
    assign sclk_raw = mode_tft ? (!ph && run) : (ph && oe_i);

    // Line data register, loaded from the source or cleared each pixel.
    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= '0;
        else if (step) data_q <= pix_pop ? pix_data : '0;
    end

    assign lcd_hsync = hs_i ^ pol_hs;
    assign lcd_vsync = vs_i ^ pol_vs;
    assign lcd_oe    = oe_i ^ pol_oe;
    assign lcd_sclk  = sclk_raw ^ pol_clk;
    assign lcd_data  = data_q;

    assert_data_zero_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_i |-> (data_q == '0));
    assert_vs_with_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_i) |-> hs_i);
    assert_data_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_i && !$stable(data_q)) |-> ph);

endmodule

// File: rtl/lcd_raster_timer.sv
// Top of the LCD raster timer: shadow configuration, line and frame
// sequencers and the pin stage.
// Assumes: xmax, ymax and hsync_len are at least 1.
module lcd_raster_timer
    import lcd_timing_pkg::*;
#(
    parameter int XW = 10,
    parameter int YW = 10,
    parameter int HW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_tft,
    input  logic [XW-1:0] xmax,
    input  logic [YW-1:0] ymax,
    input  logic [HW-1:0] hsync_len,
    input  logic [HW-1:0] gap_post,
    input  logic [HW-1:0] gap_pre,
    input  logic [YW-1:0] frame_wait,
    input  logic          pol_vs,
    input  logic          pol_hs,
    input  logic          pol_clk,
    input  logic          pol_oe,
    input  logic [DW-1:0] pix_data,
    output logic          pix_pop,
    output logic          lcd_sclk,
    output logic          lcd_hsync,
    output logic          lcd_vsync,
    output logic          lcd_oe,
    output logic [DW-1:0] lcd_data
);

    localparam int SW = 5 + XW + 2 * YW + 3 * HW;

    logic          tft_q, pvs_q, phs_q, pclk_q, poe_q;
    logic [XW-1:0] xmax_q;
    logic [YW-1:0] ymax_q, fwait_q;
    logic [HW-1:0] hlen_q, gpost_q, gpre_q;
    logic          frame_load, ph, step, line_start, first_start, into_act;
    logic          v_first, v_active;
    hphase_t       hph;

    lcd_cfg_shadow #(.W(SW)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_load),
        .d     ({mode_tft, pol_vs, pol_hs, pol_clk, pol_oe,
                 xmax, ymax, frame_wait, hsync_len, gap_post, gap_pre}),
        .q     ({tft_q, pvs_q, phs_q, pclk_q, poe_q,
                 xmax_q, ymax_q, fwait_q, hlen_q, gpost_q, gpre_q})
    );

    lcd_line_seq #(.XW(XW), .HW(HW)) u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .xmax        (xmax_q),
        .hsync_len   (hlen_q),
        .gap_post    (gpost_q),
        .gap_pre     (gpre_q),
        .ph          (ph),
        .step        (step),
        .hph         (hph),
        .line_start  (line_start),
        .first_start (first_start),
        .into_act    (into_act)
    );

    lcd_frame_seq #(.YW(YW)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_tft    (tft_q),
        .ymax        (ymax_q),
        .frame_wait  (fwait_q),
        .line_start  (line_start),
        .first_start (first_start),
        .frame_load  (frame_load),
        .v_first     (v_first),
        .v_active    (v_active)
    );

    lcd_pin_drive #(.DW(DW)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .ph        (ph),
        .step      (step),
        .hph       (hph),
        .v_first   (v_first),
        .v_active  (v_active),
        .into_act  (into_act),
        .mode_tft  (tft_q),
        .pol_vs    (pvs_q),
        .pol_hs    (phs_q),
        .pol_clk   (pclk_q),
        .pol_oe    (poe_q),
        .pix_data  (pix_data),
        .pix_pop   (pix_pop),
        .lcd_sclk  (lcd_sclk),
        .lcd_hsync (lcd_hsync),
        .lcd_vsync (lcd_vsync),
        .lcd_oe    (lcd_oe),
        .lcd_data  (lcd_data)
    );

endmodule

// File: tb/lcd_raster_timer_tb.sv
// Directed bench for the LCD raster timer; one task per scenario.
module lcd_raster_timer_tb;

    localparam int XW = 10, YW = 10, HW = 8, DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_tft = 1'b1;
    logic [XW-1:0] xmax = 10'd5;
    logic [YW-1:0] ymax = 10'd4;
    logic [HW-1:0] hsync_len = 8'd2, gap_post = 8'd3, gap_pre = 8'd1;
    logic [YW-1:0] frame_wait = 10'd2;
    logic          pol_vs = 1'b0, pol_hs = 1'b0, pol_clk = 1'b0, pol_oe = 1'b0;
    logic [DW-1:0] src = 16'd1;
    logic          pix_pop, lcd_sclk, lcd_hsync, lcd_vsync, lcd_oe;
    logic [DW-1:0] lcd_data;

    // Polarity the bench assumes is in force, for logical levels.
    bit p_vs = 0, p_hs = 0, p_clk = 0, p_oe = 0;
    int checks = 0, errors = 0, pop_cnt = 0;

    always #10 clk = !clk;

    lcd_raster_timer #(.XW(XW), .YW(YW), .HW(HW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_tft(mode_tft), .xmax(xmax), .ymax(ymax),
        .hsync_len(hsync_len), .gap_post(gap_post), .gap_pre(gap_pre),
        .frame_wait(frame_wait), .pol_vs(pol_vs), .pol_hs(pol_hs),
        .pol_clk(pol_clk), .pol_oe(pol_oe), .pix_data(src), .pix_pop(pix_pop),
        .lcd_sclk(lcd_sclk), .lcd_hsync(lcd_hsync), .lcd_vsync(lcd_vsync),
        .lcd_oe(lcd_oe), .lcd_data(lcd_data)
    );

    // Pixel source: advance on every pop.
    always @(posedge clk) begin
        if (rst_n && pix_pop) begin
            src     <= src + 16'd1;
            pop_cnt <= pop_cnt + 1;
        end
    end

    function automatic bit lv(input int sel);
        case (sel)
            0:       return lcd_hsync ^ p_hs;
            1:       return lcd_vsync ^ p_vs;
            2:       return lcd_oe ^ p_oe;
            default: return lcd_sclk ^ p_clk;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_rise(input int sel);
        int n = 0;
        while (lv(sel) && n < 3000) begin @(negedge clk); n++; end
        while (!lv(sel) && n < 3000) begin @(negedge clk); n++; end
        if (n >= 3000) check(0, "timeout", n, 0);
    endtask

    // R1: inactive levels held in reset, for both polarity settings.
    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check({lcd_hsync, lcd_vsync, lcd_oe, lcd_sclk} == 4'b0000, "R1 pol0 levels",
              {lcd_hsync, lcd_vsync, lcd_oe, lcd_sclk}, 0);
        check(lcd_data == 0 && !pix_pop, "R1 data idle", lcd_data, 0);
        {pol_vs, pol_hs, pol_clk, pol_oe} = 4'b1111;
        repeat (3) @(negedge clk);
        check({lcd_hsync, lcd_vsync, lcd_oe, lcd_sclk} == 4'b1111, "R1 pol1 levels",
              {lcd_hsync, lcd_vsync, lcd_oe, lcd_sclk}, 15);
        {pol_vs, pol_hs, pol_clk, pol_oe} = 4'b0000;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Measure one line from a sync start; returns clock counts per phase.
    task automatic measure_line(output int hs_n, output int bp_n, output int oe_n,
                                output int fp_n, output bit seq_ok);
        logic [DW-1:0] v0;
        hs_n = 0; bp_n = 0; oe_n = 0; fp_n = 0; seq_ok = 1;
        wait_rise(0);
        while (lv(0)) begin hs_n++; @(negedge clk); end
        while (!lv(2) && !lv(0)) begin bp_n++; @(negedge clk); end
        v0 = lcd_data;
        while (lv(2)) begin
            if (lcd_data != v0 + DW'(oe_n / 2)) seq_ok = 0;
            oe_n++; @(negedge clk);
        end
        while (!lv(0)) begin
            if (lcd_data != 0) seq_ok = 0;
            fp_n++; @(negedge clk);
        end
    endtask

    // R2 and R3: phase lengths and data sequence of one active line.
    task automatic t_line;
        int a, b, c, d; bit ok;
        measure_line(a, b, c, d, ok);
        check(a == 4, "R2 sync width", a, 4);
        check(b == 6, "R2 pre-data gap", b, 6);
        check(c == 10, "R2 R3 enable width", c, 10);
        check(d == 6, "R2 post-data gap", d, 6);
        check(ok, "R3 data order and zero when disabled", ok, 1);
    endtask

    // One frame from a vertical sync start: line counts, widths, clocks.
    task automatic t_frame(input bit passive, input int exp_lines, input string tag);
        int clks = 0, lines = 1, oes = 0, vs_w = 1, p0;
        bit clk_ok = 1, edge_ok = 1, zero_ok = 1, phs, poe, psc, pvs, c_hs, c_oe, c_sc, c_vs;
        logic [DW-1:0] pd;
        wait_rise(1);
        check(lv(0), {tag, " R4 vsync starts with hsync"}, lv(0), 1);
        p0 = pop_cnt;
        phs = lv(0); poe = lv(2); psc = lv(3); pvs = 1; pd = lcd_data;
        if (poe) oes = 1;
        forever begin
            @(negedge clk); clks++;
            c_hs = lv(0); c_vs = lv(1); c_oe = lv(2); c_sc = lv(3);
            if ((c_vs && !pvs) || clks > 2000) break;
            if (c_hs && !phs) lines++;
            if (c_oe && !poe) oes++;
            if (c_vs) vs_w++;
            if (!passive && c_sc == psc) clk_ok = 0;
            if (passive && !c_oe && c_sc) clk_ok = 0;
            if (!c_oe && lcd_data != 0) zero_ok = 0;
            if (c_oe && poe && lcd_data != pd)
                if (passive ? !(c_sc && !psc) : !(!c_sc && psc)) edge_ok = 0;
            phs = c_hs; poe = c_oe; psc = c_sc; pvs = c_vs; pd = lcd_data;
        end
        check(lines == exp_lines, {tag, " R5 lines per frame"}, lines, exp_lines);
        check(oes == 4, {tag, " R5 enabled lines"}, oes, 4);
        check(clks == 26 * exp_lines, {tag, " R2 frame clocks"}, clks, 26 * exp_lines);
        check(vs_w == 26, {tag, " R4 vsync one line"}, vs_w, 26);
        check(pop_cnt - p0 == 20, {tag, " R3 pops per frame"}, pop_cnt - p0, 20);
        check(zero_ok, {tag, " R3 data zero when disabled"}, zero_ok, 1);
        if (passive) begin
            check(clk_ok, {tag, " R7 clock idle outside data"}, clk_ok, 1);
            check(edge_ok, {tag, " R7 data on rising clock"}, edge_ok, 1);
        end else begin
            check(clk_ok, {tag, " R6 clock free running"}, clk_ok, 1);
            check(edge_ok, {tag, " R6 data on falling clock"}, edge_ok, 1);
        end
    endtask

    // R9: mid-frame write waits for the next frame.
    task automatic t_midframe;
        int a, b, c, d; bit ok;
        wait_rise(1);
        xmax = 10'd7;
        measure_line(a, b, c, d, ok);
        check(c == 10, "R9 old width kept mid-frame", c, 10);
        wait_rise(1);
        measure_line(a, b, c, d, ok);
        check(c == 14, "R9 new width next frame", c, 14);
        xmax = 10'd5;
        repeat (400) @(negedge clk);
    endtask

    // Mode or polarity change applied through a frame boundary.
    task automatic apply_cfg(input bit tft, input bit pol);
        mode_tft = tft;
        {pol_vs, pol_hs, pol_clk, pol_oe} = {4{pol}};
        repeat (400) @(negedge clk);
        {p_vs, p_hs, p_clk, p_oe} = {4{pol}};
    endtask

    // R8: inverted polarities on a passive frame.
    task automatic t_polarity;
        apply_cfg(1'b0, 1'b1);
        t_frame(1'b1, 6, "pol1");
        wait_rise(1);
        repeat (30) @(negedge clk);
        check(lcd_sclk == 1'b1 && lcd_vsync == 1'b1, "R8 inverted idle levels",
              {lcd_sclk, lcd_vsync}, 3);
        check(lv(0) == 1'b0 || lcd_hsync == 1'b0, "R8 hsync active low",
              lcd_hsync, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_line();
        t_frame(1'b0, 4, "tft");
        t_midframe();
        apply_cfg(1'b0, 1'b0);
        t_frame(1'b1, 6, "passive");
        t_line();
        t_polarity();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule